// File: doc/BRIEF.md
# Four-Lane Masked Integer Vector Unit

This unit carries out one element-wise integer operation over a vector held in an external register file. Supported operations are add, subtract, and compare-not-equal against a scalar. Elements are dealt to four lanes by index: element i runs in lane i mod 4, as part of group i / 4. One group of four elements is issued each cycle. A vector length set at start time limits the elements that take effect. A 64-bit per-element predicate register can gate which elements write back.

The unit reads operands combinationally from the register file. It drives the source register numbers and the current group on its read outputs, and receives four source-A elements and four source-B elements on the same cycle. Results come back through four per-lane write strobes that share one destination register number and one group number. The compare operation writes no vector register. It refreshes the predicate register instead, which stays visible on an output. A done pulse marks the end of each operation. A start request made while an operation is running is dropped.

Top module: `vmu_top`

## Requirements
- R1: After reset, busy_o and done_o are 0, wb_we_o is all zero and every bit of mask_o is 1.
- R2: Element i is written through lane i mod 4 during the cycle where wb_grp_o equals i / 4. wb_reg_o carries the destination register. Lane k data sits at wb_data_o[16k+15:16k]. Groups are issued on consecutive cycles in ascending order.
- R3: op_i encoding: 0 adds A+B, 1 subtracts A-B, 2 is compare-not-equal, 3 adds. Sums and differences wrap modulo 2^16.
- R4: Only elements below the effective length are written. A vl_i above 64 acts as 64. A vl_i of 0 writes nothing.
- R5: With use_mask_i at 1, an add or subtract element whose mask bit is 0 is not written. It still occupies its issue slot, so completion timing equals the unmasked case.
- R6: With use_mask_i at 0, every in-range element is written whatever the mask holds.
- R7: op 2 sets mask bit i to 1 when source-A element i differs from scalar_i, and to 0 otherwise, for i below the effective length. Higher mask bits are left unchanged, and no write strobe rises.
- R8: A start request seen at a clock edge with busy_o low is accepted at that edge. done_o is then high for exactly one cycle, starting G+2 edges later, where G is the larger of 1 and ceil(length/4). busy_o stays high from acceptance until the edge where done_o rises.
- R9: A start request while busy_o is high is ignored. It causes no writes, no mask change and no second done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation request |
| op_i | input | 2 | Opcode |
| use_mask_i | input | 1 | Gate writes by mask register |
| vd_i | input | 4 | Destination register |
| va_i | input | 4 | Source A register |
| vb_i | input | 4 | Source B register |
| vl_i | input | 7 | Requested vector length |
| scalar_i | input | 16 | Compare operand |
| rd_reg_a_o | output | 4 | Register read for source A |
| rd_reg_b_o | output | 4 | Register read for source B |
| rd_grp_o | output | 4 | Element group being read |
| rd_a_i | input | 64 | Four source-A elements of that group |
| rd_b_i | input | 64 | Four source-B elements of that group |
| wb_we_o | output | 4 | Per-lane write strobe |
| wb_reg_o | output | 4 | Write-back register |
| wb_grp_o | output | 4 | Write-back group |
| wb_data_o | output | 64 | Per-lane write data |
| mask_o | output | 64 | Mask register |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |

## Verification
The hardest case to reach is a masked operation whose predicate came from an earlier compare rather than from reset. The bench builds that state in two steps. First it runs compares whose length is shorter than the vector, so the upper mask bits keep values from before. Then it issues a masked subtract that reads and writes the same register. This shows that bubbles keep their slots and that partial mask updates persist. A second start request is injected in the middle of a long operation, and the bench checks that no stray write or mask update follows.

// File: rtl/vmu_pkg.sv
package vmu_pkg;
  typedef enum logic [1:0] {
    VOP_ADD   = 2'd0,
    VOP_SUB   = 2'd1,
    VOP_CMPNE = 2'd2,
    VOP_ADD_B = 2'd3
  } vop_e;
endpackage

// File: rtl/vmu_seq.sv
module vmu_seq import vmu_pkg::*; #(
  parameter int LANES = 4,
  parameter int MAXVL = 64,
  parameter int NREGS = 16,
  parameter int W     = 16,
  localparam int GRPS = MAXVL / LANES,
  localparam int GW   = $clog2(GRPS),
  localparam int LW   = $clog2(LANES),
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int RW   = $clog2(NREGS),
  localparam int EW   = $clog2(MAXVL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             use_mask_i,
  input  logic [RW-1:0]    vd_i,
  input  logic [RW-1:0]    va_i,
  input  logic [RW-1:0]    vb_i,
  input  logic [VLW-1:0]   vl_i,
  input  logic [W-1:0]     scalar_i,
  input  logic [MAXVL-1:0] mask_i,
  input  logic             retire_last_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             issue_o,
  output logic             issue_last_o,
  output logic [GW-1:0]    grp_o,
  output logic [LANES-1:0] lane_en_o,
  output vop_e             op_o,
  output logic             use_mask_o,
  output logic [RW-1:0]    vd_o,
  output logic [RW-1:0]    va_o,
  output logic [RW-1:0]    vb_o,
  output logic [VLW-1:0]   vl_o,
  output logic [W-1:0]     scalar_o
);
  logic busy_q, issue_q, done_q, msk_q;
  logic [GW-1:0] grp_q, last_q, last_d;
  vop_e op_q;
  logic [RW-1:0] vd_q, va_q, vb_q;
  logic [VLW-1:0] vl_q, vl_clamp, vl_m1;
  logic [W-1:0] sc_q;
  logic accept;

  assign accept   = start_i & ~busy_q;
  assign vl_clamp = (vl_i > VLW'(MAXVL)) ? VLW'(MAXVL) : vl_i;
  assign vl_m1    = vl_clamp - VLW'(1);
  assign last_d   = (vl_clamp == '0) ? '0 : GW'(vl_m1 >> LW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      issue_q <= 1'b0;
      done_q  <= 1'b0;
      grp_q   <= '0;
      last_q  <= '0;
      op_q    <= VOP_ADD;
      msk_q   <= 1'b0;
      vd_q    <= '0;
      va_q    <= '0;
      vb_q    <= '0;
      vl_q    <= '0;
      sc_q    <= '0;
    end else begin
      done_q <= retire_last_i;
      if (accept) begin
        busy_q  <= 1'b1;
        issue_q <= 1'b1;
        grp_q   <= '0;
        last_q  <= last_d;
        op_q    <= vop_e'(op_i);
        msk_q   <= use_mask_i;
        vd_q    <= vd_i;
        va_q    <= va_i;
        vb_q    <= vb_i;
        vl_q    <= vl_clamp;
        sc_q    <= scalar_i;
      end else begin
        if (issue_q) begin
          if (grp_q == last_q) issue_q <= 1'b0;
          else                 grp_q   <= grp_q + GW'(1);
        end
        if (retire_last_i) busy_q <= 1'b0;
      end
    end
  end

  // masked-off elements still hold their slot: only the strobe is dropped
  for (genvar k = 0; k < LANES; k++) begin : g_en
    logic [EW-1:0] elem;
    assign elem = {grp_q, LW'(k)};
    assign lane_en_o[k] = issue_q && ({1'b0, elem} < vl_q) &&
                          ((op_q == VOP_CMPNE) || !msk_q || mask_i[elem]);
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign issue_o      = issue_q;
  assign issue_last_o = issue_q && (grp_q == last_q);
  assign grp_o        = grp_q;
  assign op_o         = op_q;
  assign use_mask_o   = msk_q;
  assign vd_o         = vd_q;
  assign va_o         = va_q;
  assign vb_o         = vb_q;
  assign vl_o         = vl_q;
  assign scalar_o     = sc_q;

  p_ignore_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> $stable(vd_q) && $stable(op_q) && $stable(vl_q));
  p_grp_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_q |-> grp_q <= last_q);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
endmodule

// File: rtl/vmu_lane.sv
module vmu_lane import vmu_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  vop_e         op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] scalar_i,
  output logic         we_o,
  output logic [W-1:0] data_o,
  output logic         cmp_we_o,
  output logic         cmp_bit_o
);
  logic         en1_q, we_q, cw_q, cb_q;
  logic [W-1:0] a1_q, b1_q, d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en1_q <= 1'b0;
      a1_q  <= '0;
      b1_q  <= '0;
      we_q  <= 1'b0;
      d_q   <= '0;
      cw_q  <= 1'b0;
      cb_q  <= 1'b0;
    end else begin
      en1_q <= en_i;
      a1_q  <= a_i;
      b1_q  <= b_i;
      we_q  <= en1_q && (op_i != VOP_CMPNE);
      d_q   <= (op_i == VOP_SUB) ? a1_q - b1_q : a1_q + b1_q;
      cw_q  <= en1_q && (op_i == VOP_CMPNE);
      cb_q  <= a1_q != scalar_i;
    end
  end

  assign we_o      = we_q;
  assign data_o    = d_q;
  assign cmp_we_o  = cw_q;
  assign cmp_bit_o = cb_q;

  p_single_kind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && cmp_we_o));
endmodule

// File: rtl/vmu_mask.sv
module vmu_mask #(
  parameter int LANES = 4,
  parameter int MAXVL = 64,
  localparam int GRPS = MAXVL / LANES,
  localparam int GW   = $clog2(GRPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] wr_en_i,
  input  logic [GW-1:0]    wr_grp_i,
  input  logic [LANES-1:0] wr_bit_i,
  output logic [MAXVL-1:0] mask_o
);
  logic [MAXVL-1:0] mask_q;

  for (genvar e = 0; e < MAXVL; e++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mask_q[e] <= 1'b1;
      else if (wr_en_i[e % LANES] && (wr_grp_i == GW'(e / LANES)))
        mask_q[e] <= wr_bit_i[e % LANES];
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/vmu_top.sv
module vmu_top import vmu_pkg::*; #(
  parameter int LANES = 4,
  parameter int MAXVL = 64,
  parameter int NREGS = 16,
  parameter int W     = 16,
  localparam int GRPS = MAXVL / LANES,
  localparam int GW   = $clog2(GRPS),
  localparam int LW   = $clog2(LANES),
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int RW   = $clog2(NREGS),
  localparam int EW   = $clog2(MAXVL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         op_i,
  input  logic               use_mask_i,
  input  logic [RW-1:0]      vd_i,
  input  logic [RW-1:0]      va_i,
  input  logic [RW-1:0]      vb_i,
  input  logic [VLW-1:0]     vl_i,
  input  logic [W-1:0]       scalar_i,
  output logic [RW-1:0]      rd_reg_a_o,
  output logic [RW-1:0]      rd_reg_b_o,
  output logic [GW-1:0]      rd_grp_o,
  input  logic [LANES*W-1:0] rd_a_i,
  input  logic [LANES*W-1:0] rd_b_i,
  output logic [LANES-1:0]   wb_we_o,
  output logic [RW-1:0]      wb_reg_o,
  output logic [GW-1:0]      wb_grp_o,
  output logic [LANES*W-1:0] wb_data_o,
  output logic [MAXVL-1:0]   mask_o,
  output logic               busy_o,
  output logic               done_o
);
  logic             issue, issue_last, use_mask;
  logic [GW-1:0]    grp;
  logic [LANES-1:0] lane_en, cmp_we, cmp_bit;
  vop_e             op;
  logic [RW-1:0]    vd, va, vb;
  logic [VLW-1:0]   vl;
  logic [W-1:0]     scalar;
  logic             s1_v_q, s1_last_q, s2_v_q, s2_last_q, retire_last;
  logic [GW-1:0]    s1_grp_q, s2_grp_q;

  vmu_seq #(.LANES(LANES), .MAXVL(MAXVL), .NREGS(NREGS), .W(W)) u_seq (
    .clk_i, .rst_ni, .start_i, .op_i, .use_mask_i, .vd_i, .va_i, .vb_i, .vl_i,
    .scalar_i, .mask_i(mask_o), .retire_last_i(retire_last),
    .busy_o, .done_o, .issue_o(issue), .issue_last_o(issue_last), .grp_o(grp),
    .lane_en_o(lane_en), .op_o(op), .use_mask_o(use_mask), .vd_o(vd),
    .va_o(va), .vb_o(vb), .vl_o(vl), .scalar_o(scalar)
  );

  // group tag travels alongside the two lane stages
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q <= 1'b0; s1_last_q <= 1'b0; s1_grp_q <= '0;
      s2_v_q <= 1'b0; s2_last_q <= 1'b0; s2_grp_q <= '0;
    end else begin
      s1_v_q    <= issue;
      s1_last_q <= issue_last;
      s1_grp_q  <= grp;
      s2_v_q    <= s1_v_q;
      s2_last_q <= s1_last_q;
      s2_grp_q  <= s1_grp_q;
    end
  end

  assign retire_last = s2_v_q && s2_last_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vmu_lane #(.W(W)) u_lane (
      .clk_i, .rst_ni,
      .en_i(lane_en[k]), .op_i(op),
      .a_i(rd_a_i[k*W +: W]), .b_i(rd_b_i[k*W +: W]), .scalar_i(scalar),
      .we_o(wb_we_o[k]), .data_o(wb_data_o[k*W +: W]),
      .cmp_we_o(cmp_we[k]), .cmp_bit_o(cmp_bit[k])
    );

    logic [EW-1:0] wb_elem;
    assign wb_elem = {s2_grp_q, LW'(k)};

    p_we_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_we_o[k] |-> ({1'b0, wb_elem} < vl));
    p_masked_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_we_o[k] && use_mask |-> mask_o[wb_elem]);
    p_we_in_retire_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_we_o[k] |-> s2_v_q && busy_o);
  end

  vmu_mask #(.LANES(LANES), .MAXVL(MAXVL)) u_mask (
    .clk_i, .rst_ni, .wr_en_i(cmp_we), .wr_grp_i(s2_grp_q),
    .wr_bit_i(cmp_bit), .mask_o
  );

  assign rd_reg_a_o = va;
  assign rd_reg_b_o = vb;
  assign rd_grp_o   = grp;
  assign wb_reg_o   = vd;
  assign wb_grp_o   = s2_grp_q;

  p_cmp_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (op == VOP_CMPNE) |-> wb_we_o == '0);
  p_mask_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(mask_o));
endmodule

// File: tb/vmu_top_test.sv
`timescale 1ns/1ps
module vmu_top_test;
  typedef struct packed {
    logic [3:0]  r;
    logic [5:0]  e;
    logic [15:0] d;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        use_mask = 1'b0;
  logic [3:0]  vd = '0, va = '0, vb = '0;
  logic [6:0]  vl = '0;
  logic [15:0] scalar = '0;
  logic [3:0]  rd_reg_a, rd_reg_b, rd_grp, wb_reg, wb_grp;
  logic [63:0] rd_a, rd_b, wb_data, mask;
  logic [3:0]  wb_we;
  logic        busy, done;

  logic [15:0] rf [16][64];
  logic [63:0] mask_m;
  item_t       exp_q[$];
  int          checks = 0;
  int          failures = 0;
  string       cur_req = "R2";

  always #2 clk = ~clk;

  vmu_top uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .use_mask_i(use_mask),
    .vd_i(vd), .va_i(va), .vb_i(vb), .vl_i(vl), .scalar_i(scalar),
    .rd_reg_a_o(rd_reg_a), .rd_reg_b_o(rd_reg_b), .rd_grp_o(rd_grp),
    .rd_a_i(rd_a), .rd_b_i(rd_b), .wb_we_o(wb_we), .wb_reg_o(wb_reg),
    .wb_grp_o(wb_grp), .wb_data_o(wb_data), .mask_o(mask), .busy_o(busy), .done_o(done)
  );

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      rd_a[k*16 +: 16] = rf[rd_reg_a][{rd_grp, k[1:0]}];
      rd_b[k*16 +: 16] = rf[rd_reg_b][{rd_grp, k[1:0]}];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: pop one expected item per observed lane write
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) begin
        if (wb_we[k]) begin
          logic [5:0] el;
          el = {wb_grp, k[1:0]};
          if (exp_q.size() == 0) begin
            check(1'b0, cur_req, "unexpected write elem", {58'd0, el}, 64'd0);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            check(wb_reg == it.r && el == it.e && wb_data[k*16 +: 16] == it.d, cur_req,
                  "write-back reg/elem/data", {44'd0, wb_reg, el, wb_data[k*16 +: 16]},
                  {44'd0, it});
            rf[it.r][it.e] = it.d;
          end
        end
      end
    end
  end

  task automatic run_op(input logic [1:0] o, input logic um, input int d, input int a,
                        input int b, input int l, input logic [15:0] sc,
                        input bit poke, input string req);
    int vle, g, cnt;
    logic [63:0] mnext;
    cur_req = req;
    vle = (l > 64) ? 64 : l;
    g = (vle == 0) ? 1 : (vle + 3) / 4;
    mnext = mask_m;
    for (int i = 0; i < vle; i++) begin
      if (o == 2'd2) mnext[i] = (rf[a][i] != sc);
      else if (!um || mask_m[i])
        exp_q.push_back('{r: 4'(d), e: 6'(i),
                          d: (o == 2'd1) ? rf[a][i] - rf[b][i] : rf[a][i] + rf[b][i]});
    end
    @(negedge clk);
    start = 1'b1; op = o; use_mask = um; vd = 4'(d); va = 4'(a); vb = 4'(b);
    vl = 7'(l); scalar = sc;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    check(busy == 1'b1, "R8", "busy after accept", {63'd0, busy}, 64'd1);
    while (!done && cnt < 200) begin
      if (poke && cnt == 3) begin  // R9 stray request mid-operation
        start = 1'b1; op = 2'd2; vd = 4'd15; va = 4'd0; vl = 7'd64; scalar = 16'h1234;
      end
      if (poke && cnt == 5) start = 1'b0;
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check(cnt == g + 3, req, "done timing", 64'(cnt), 64'(g + 3));
    check(busy == 1'b0, "R8", "busy clear with done", {63'd0, busy}, 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R8", "done single pulse", {63'd0, done}, 64'd0);
    check(exp_q.size() == 0, req, "pending writes", 64'(exp_q.size()), 64'd0);
    mask_m = mnext;
    check(mask == mask_m, (o == 2'd2) ? "R7" : req, "mask register", mask, mask_m);
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R9", "stays idle", {62'd0, busy, done}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < 16; r++)
      for (int e = 0; e < 64; e++)
        rf[r][e] = 16'(r * 4099 + e * 613 + 7);
    for (int e = 0; e < 64; e++) begin
      rf[1][e] = 16'hFF00 + 16'(e);
      rf[2][e] = 16'h0200 + 16'(e * 5);
      rf[5][e] = (e % 3 == 0) ? 16'h00AA : 16'(e + 1);
      rf[6][e] = 16'(e);
    end
    mask_m = '1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0, "R1", "busy/done in reset", {62'd0, busy, done}, 64'd0);
    check(wb_we == 0, "R1", "no strobes in reset", {60'd0, wb_we}, 64'd0);
    check(mask == '1, "R1", "mask all ones", mask, '1);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && wb_we == 0 && mask == '1, "R1", "state after release",
          {59'd0, busy, wb_we}, 64'd0);

    run_op(2'd0, 1'b0, 3, 1, 2, 64, 16'h0, 1'b0, "R2");   // full add, wraps
    run_op(2'd1, 1'b0, 4, 6, 1, 10, 16'h0, 1'b0, "R3");   // subtract with wrap
    run_op(2'd3, 1'b0, 7, 1, 2, 5, 16'h0, 1'b0, "R3");    // alternate add code
    run_op(2'd0, 1'b0, 8, 1, 2, 0, 16'h0, 1'b0, "R4");    // zero length
    run_op(2'd0, 1'b0, 9, 2, 6, 100, 16'h0, 1'b0, "R4");  // clamp to 64
    run_op(2'd2, 1'b0, 0, 5, 0, 37, 16'h00AA, 1'b0, "R7");
    run_op(2'd0, 1'b1, 10, 1, 2, 64, 16'h0, 1'b0, "R5");  // masked, same timing
    run_op(2'd1, 1'b0, 11, 2, 1, 23, 16'h0, 1'b0, "R6");  // mask ignored
    run_op(2'd0, 1'b0, 12, 1, 2, 40, 16'h0, 1'b1, "R9");  // stray start mid-op
    run_op(2'd2, 1'b0, 0, 6, 0, 20, 16'h0003, 1'b0, "R7"); // partial mask update
    run_op(2'd1, 1'b1, 1, 1, 2, 64, 16'h0, 1'b0, "R5");   // masked, src == dst

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule